// File: doc/BRIEF.md
# Read-Only Fully Associative Byte Cache

This block is a small read-only cache in which a memory block may sit in any line. A requester presents a 24-bit byte address. The upper 22 bits are the block tag and the low 2 bits pick one byte of a 32-bit block. Every stored tag is compared with the incoming tag in the same cycle. On a hit, the addressed byte comes back on the next cycle with no memory traffic.

On a miss the block stays busy and requests the block from a backing memory. It waits for the memory's valid pulse, then writes the fetched block into a line and returns the requested byte taken straight from the fetched data. Lines that are still empty are filled first, lowest index first. Once every line is in use, the line that was filled earliest is replaced. A rotating pointer moves only when a line is filled, so hits never change the replacement order.

Top module: `fa_fifo_cache`

## Requirements
- R1: After reset `req_ready` is 1, `resp_valid` is 0, `mem_req` is 0, and every line is empty, so the first lookup of any tag misses.
- R2: The returned byte is byte `addr[1:0]` of the 32-bit block, with byte k taken from bits 8k+7..8k.
- R3: A lookup whose tag is resident gives `resp_valid`=1 and `resp_hit`=1 on the cycle after acceptance, and it causes no memory request.
- R4: A lookup that misses holds `mem_req`=1 with `mem_addr` equal to the tag until `mem_valid` is seen. On the next cycle it gives `resp_valid`=1 and `resp_hit`=0, with the byte selected from the fetched block.
- R5: While empty lines remain, a fill never displaces a resident block. The first LINES distinct blocks all stay resident.
- R6: When all lines are in use, a fill replaces the block that was filled earliest.
- R7: Hits do not change which block is replaced next.
- R8: While a miss is outstanding `req_ready` is 0 and `req_valid` is ignored. No response and no fill result from it.
- R9: At most one line matches any tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_addr | input | TAG_W+2 | Byte address: tag then byte offset |
| req_ready | output | 1 | Lookup accepted this cycle when high |
| resp_valid | output | 1 | Response strobe |
| resp_hit | output | 1 | 1 if the response came from a resident line |
| resp_data | output | 8 | Requested byte |
| mem_req | output | 1 | Block fetch request, held until served |
| mem_addr | output | TAG_W | Tag of the block being fetched |
| mem_valid | input | 1 | Fetched block present on mem_data |
| mem_data | input | 32 | Fetched block |

## Verification
The bench first fills the cache with sixteen distinct tags. It then reads them all back at every byte offset, which separates correct residency from a premature eviction and checks the byte lane order. It then hits the oldest block many times before forcing an eviction. This tells FIFO order apart from a recency-based order. A later miss on the evicted tag confirms which line went. During one outstanding miss the bench holds a foreign request active to show that it is ignored. Every expected result comes from a list model of the resident tags.

// File: rtl/fa_fifo_cache.sv
module fa_fifo_cache #(
  parameter int LINES = 16,
  parameter int TAG_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [TAG_W+1:0] req_addr,
  output logic             req_ready,
  output logic             resp_valid,
  output logic             resp_hit,
  output logic [7:0]       resp_data,
  output logic             mem_req,
  output logic [TAG_W-1:0] mem_addr,
  input  logic             mem_valid,
  input  logic [31:0]      mem_data
);
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;

  logic [TAG_W-1:0] tag_q [LINES];
  logic [31:0]      blk_q [LINES];
  logic [LINES-1:0] vld_q;
  logic [IDX_W-1:0] ptr_q;
  logic             busy_q;
  logic [TAG_W-1:0] tag_r;
  logic [1:0]       off_r;

  logic [TAG_W-1:0] in_tag;
  logic [1:0]       in_off;
  logic [LINES-1:0] match;
  logic [31:0]      hit_blk;
  logic [IDX_W-1:0] victim;
  logic             accept;

  assign in_tag    = req_addr[TAG_W+1:2];
  assign in_off    = req_addr[1:0];
  assign req_ready = !busy_q;
  assign accept    = req_valid && !busy_q;
  assign mem_req   = busy_q;
  assign mem_addr  = tag_r;

  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (tag_q[g] == in_tag);
  end

  always_comb begin
    hit_blk = '0;
    for (int i = 0; i < LINES; i++)
      if (match[i]) hit_blk = hit_blk | blk_q[i];
  end

  always_comb begin
    victim = ptr_q;
    for (int i = LINES - 1; i >= 0; i--)
      if (!vld_q[i]) victim = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q      <= '0;
      ptr_q      <= '0;
      busy_q     <= 1'b0;
      tag_r      <= '0;
      off_r      <= '0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_valid <= 1'b0;
      if (accept) begin
        if (|match) begin
          resp_valid <= 1'b1;
          resp_hit   <= 1'b1;
          resp_data  <= hit_blk[8*in_off +: 8];
        end else begin
          busy_q <= 1'b1;
          tag_r  <= in_tag;
          off_r  <= in_off;
        end
      end else if (busy_q && mem_valid) begin
        busy_q        <= 1'b0;
        vld_q[victim] <= 1'b1;
        ptr_q         <= (victim == IDX_W'(LINES - 1)) ? '0 : victim + 1'b1;
        resp_valid    <= 1'b1;
        resp_hit      <= 1'b0;
        resp_data     <= mem_data[8*off_r +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && busy_q && mem_valid && !accept) begin
      tag_q[victim] <= tag_r;
      blk_q[victim] <= mem_data;
    end
  end
endmodule

module fa_fifo_cache_chk #(
  parameter int LINES = 16,
  parameter int TAG_W = 22
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [LINES-1:0] match,
  input logic             resp_valid,
  input logic             resp_hit,
  input logic             mem_req,
  input logic [TAG_W-1:0] mem_addr,
  input logic             mem_valid
);
  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match)); // R9
  AST_HIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (|match) |=> resp_valid && resp_hit && !mem_req); // R3
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |=> mem_req && $stable(mem_addr)); // R4
  AST_FILL_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_valid |=> resp_valid && !resp_hit && !mem_req); // R4
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready); // R8
endmodule

bind fa_fifo_cache fa_fifo_cache_chk #(.LINES(LINES), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .match(match), .resp_valid(resp_valid), .resp_hit(resp_hit),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid)
);

// File: tb/fa_fifo_cache_tb.sv
`timescale 1ns/1ps
module fa_fifo_cache_tb;
  localparam int LINES = 16;
  localparam int TAG_W = 22;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic [TAG_W+1:0] req_addr = '0;
  logic             req_ready, resp_valid, resp_hit, mem_req;
  logic [7:0]       resp_data;
  logic [TAG_W-1:0] mem_addr;
  logic             mem_valid = 1'b0;
  logic [31:0]      mem_data = '0;

  int checks = 0, fails = 0, cycles = 0, mcnt = 0;
  logic [8:0]       expq [$];
  logic [TAG_W-1:0] model [$];
  logic [TAG_W-1:0] last_miss = '0;

  always #2.5 clk = ~clk;

  fa_fifo_cache #(.LINES(LINES), .TAG_W(TAG_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_data(resp_data), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_data(mem_data));

  function automatic logic [31:0] blk_of(logic [TAG_W-1:0] t);
    return {t[7:0] ^ 8'h3C, t[15:8] ^ 8'h5A, t[7:0] + 8'd1, t[21:14] ^ 8'hC3};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (mem_valid) begin
      mem_valid <= 1'b0;
      mcnt <= 0;
    end else if (mem_req) begin
      if (mcnt == 2) begin
        mem_valid <= 1'b1;
        mem_data  <= blk_of(mem_addr);
      end
      mcnt <= mcnt + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && mem_req)
      chk(mem_addr == last_miss, "R4 mem_addr", int'(mem_addr), int'(last_miss));
    if (rst_n && resp_valid) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R8 unexpected response", 1, 0);
      end else begin
        logic [8:0] e;
        e = expq.pop_front();
        chk({resp_hit, resp_data} == e, e[8] ? "R3/R2 hit byte" : "R4/R2 miss byte",
            int'({resp_hit, resp_data}), int'(e));
      end
    end
  end

  task automatic access(input logic [TAG_W-1:0] t, input logic [1:0] off);
    bit hit = 1'b0;
    logic [31:0] b = blk_of(t);
    foreach (model[k]) if (model[k] == t) hit = 1'b1;
    if (!hit) begin
      if (model.size() == LINES) void'(model.pop_front());
      model.push_back(t);
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    if (!hit) last_miss = t;
    expq.push_back({hit, b[8*off +: 8]});
    req_valid = 1'b1;
    req_addr  = {t, off};
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [TAG_W-1:0] tg(int i);
    return TAG_W'(22'h2A000 + i * 22'h1357);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    chk(resp_valid == 1'b0, "R1 resp_valid", resp_valid, 0);
    chk(mem_req == 1'b0, "R1 mem_req", mem_req, 0);

    for (int i = 0; i < LINES; i++) access(tg(i), 2'(i));          // R1 R5 misses
    for (int o = 0; o < 4; o++)
      for (int i = 0; i < LINES; i++) access(tg(i), 2'(o));        // R5 R2 hits
    for (int i = 0; i < 5; i++) access(tg(0), 2'(i));              // R7 hits on oldest
    access(tg(16), 2'd1);                                          // R6 evicts tg(0)
    access(tg(0), 2'd3);                                           // R6 R7 miss, evicts tg(1)
    access(tg(2), 2'd0);                                           // hit
    access(tg(1), 2'd2);                                           // miss

    access(tg(40), 2'd1);                                          // R8 miss, then foreign request
    @(negedge clk);
    while (!req_ready) begin
      req_valid = 1'b1;
      req_addr  = {tg(41), 2'd0};
      @(negedge clk);
    end
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R8 no extra response", expq.size(), 0);
    access(tg(41), 2'd0);                                          // R8 still a miss
    access(tg(40), 2'd2);

    repeat (10) @(negedge clk);
    chk(expq.size() == 0, "R4 all responses seen", expq.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule